// File: doc/BRIEF.md
# Differential-Peak Bit Demodulator

This block turns a stream of signed fixed-point samples of a recovered chaotic waveform back into framed data words. Every sample that arrives with its valid strobe is checked for a local extremum. Each extremum is compared with the last extremum of the same polarity: a clear rise decodes as 1, a clear fall decodes as 0. A rise or fall inside the noise band decodes as nothing and is counted as an erasure.

Decoded bits collect into a frame of `N` bits. The first `S` bits of each frame are synchronization bits, and they are compared with a programmable expected pattern. If they match, the frame completes after `N` bits and the remaining `N-S` information bits appear on a parallel word together with a one-cycle valid pulse. If they do not match, a mismatch pulse is raised and the bit collection restarts at once. The bit buffer empties after each frame. The per-polarity peak references carry on across frames, because the waveform itself is continuous.

Top module: `dpk_demod`

## Requirements
- R1: While `rst_n` is low and just after it, `word_vld`, `sync_miss`, `erase_cnt` and `word` are all zero.
- R2: A sample accepted with `smp_vld` high is a positive peak when it is strictly greater than both the accepted sample before it and the one after it. It is a negative peak when it is strictly smaller than both. A peak is decided on the cycle its successor is accepted. Equal neighbours (a plateau) give no peak.
- R3: For a peak whose polarity already has a reference, take `diff` = peak minus reference. If `diff > thr_rise` the decoded bit is 1. Otherwise, if `diff < thr_fall`, the decoded bit is 0. The peak then becomes the new reference for its polarity.
- R4: The first positive peak and the first negative peak after reset only set the references. They produce neither a bit nor an erasure.
- R5: A referenced peak whose `diff` decodes to no bit adds one to `erase_cnt`, which saturates at all ones. Such a peak leaves the frame bit count unchanged.
- R6: After `N` bits are decoded, `word` holds decoded bits `S+1` to `N`, with the earliest information bit in the MSB. `word_vld` is high for exactly the one cycle after the cycle in which the sample deciding the `N`-th bit was accepted.
- R7: The first `S` decoded bits of a frame, earliest in the MSB, are compared with `sync_exp`. On a mismatch, `sync_miss` pulses with the same timing as in R6, those bits are dropped and the next decoded bit starts a new frame.
- R8: Frames follow one another without gaps, each decoded independently of the last, and the peak references carry over across frame boundaries.
- R9: Cycles with `smp_vld` low change nothing, whatever value `smp` carries on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample valid strobe |
| smp | input | W | Signed sample |
| thr_rise | input | W | Signed threshold above which a difference decodes as 1 |
| thr_fall | input | W | Signed threshold below which a difference decodes as 0 |
| sync_exp | input | S | Expected synchronization pattern, earliest bit in MSB |
| word | output | N-S | Recovered information word, earliest bit in MSB |
| word_vld | output | 1 | One-cycle pulse marking a new word |
| sync_miss | output | 1 | One-cycle pulse on a synchronization mismatch |
| erase_cnt | output | EW | Saturating count of undecided peaks |

## Verification
The hardest conditions to reach from the ports are the ones where a peak is seen but no bit is decided. These are a plateau that hides a peak, an in-band difference, and the reference-only first peaks. Each of them would shift the frame alignment by one bit if handled wrongly. The bench therefore builds its sample streams from a zigzag model that knows both polarity references. It places each hazard in the middle of a frame and then checks that the word completed afterwards still matches exactly. Saturation of the erasure count is reached by streaming several hundred small in-band steps.

// File: rtl/dpk_demod.sv
module dpk_demod #(
  parameter int W  = 12,
  parameter int N  = 10,
  parameter int S  = 2,
  parameter int EW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_vld,
  input  logic signed [W-1:0] smp,
  input  logic signed [W-1:0] thr_rise,
  input  logic signed [W-1:0] thr_fall,
  input  logic [S-1:0]        sync_exp,
  output logic [N-S-1:0]      word,
  output logic                word_vld,
  output logic                sync_miss,
  output logic [EW-1:0]       erase_cnt
);
  localparam int CW = $clog2(N + 1);

  logic signed [W-1:0] s1, s2, pos_ref, neg_ref, ref_v;
  logic [1:0]          fill;
  logic                pos_ok, neg_ok, ref_ok;
  logic                is_max, is_min, pk, bit_hi, bit_lo, dec, ers;
  logic signed [W:0]   diff;
  logic [CW-1:0]       cnt;
  logic [N-1:0]        sh, nxt;

  assign is_max = smp_vld && (fill == 2'd2) && (s1 > s2) && (s1 > smp);
  assign is_min = smp_vld && (fill == 2'd2) && (s1 < s2) && (s1 < smp);
  assign pk     = is_max || is_min;
  assign ref_v  = is_max ? pos_ref : neg_ref;
  assign ref_ok = is_max ? pos_ok : neg_ok;
  assign diff   = $signed({s1[W-1], s1}) - $signed({ref_v[W-1], ref_v});
  assign bit_hi = diff > $signed({thr_rise[W-1], thr_rise});
  assign bit_lo = diff < $signed({thr_fall[W-1], thr_fall});
  assign dec    = pk && ref_ok && (bit_hi || bit_lo);
  assign ers    = pk && ref_ok && !(bit_hi || bit_lo);
  assign nxt    = {sh[N-2:0], bit_hi};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; fill <= '0;
      pos_ref <= '0; neg_ref <= '0; pos_ok <= 1'b0; neg_ok <= 1'b0;
    end else if (smp_vld) begin
      s2 <= s1;
      s1 <= smp;
      if (fill != 2'd2) fill <= fill + 2'd1;
      if (is_max) begin pos_ref <= s1; pos_ok <= 1'b1; end
      if (is_min) begin neg_ref <= s1; neg_ok <= 1'b1; end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; sh <= '0; word <= '0;
      word_vld <= 1'b0; sync_miss <= 1'b0; erase_cnt <= '0;
    end else begin
      word_vld  <= 1'b0;
      sync_miss <= 1'b0;
      if (ers && erase_cnt != {EW{1'b1}}) erase_cnt <= erase_cnt + 1'b1;
      if (dec) begin
        if (cnt == CW'(S - 1) && nxt[S-1:0] != sync_exp) begin
          sync_miss <= 1'b1;
          cnt <= '0;
          sh  <= '0;
        end else if (cnt == CW'(N - 1)) begin
          word     <= nxt[N-S-1:0];
          word_vld <= 1'b1;
          cnt <= '0;
          sh  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
          sh  <= nxt;
        end
      end
    end
  end

  assert_vld_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);
  assert_vld_after_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> $past(smp_vld));
  assert_miss_after_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_miss |-> ($past(smp_vld) && !word_vld));
  assert_erase_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_cnt == $past(erase_cnt)) || (erase_cnt == $past(erase_cnt) + 1'b1));
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_vld) |-> ($stable(erase_cnt) && !word_vld && !sync_miss));
  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(N));
endmodule

// File: tb/dpk_demod_bench.sv
module dpk_demod_bench;
  localparam int W = 12, N = 10, S = 2, EW = 8;

  logic clk = 1'b0, rst_n = 1'b0, smp_vld = 1'b0;
  logic signed [W-1:0] smp = '0, thr_rise = 12'sd10, thr_fall = -12'sd10;
  logic [S-1:0] sync_exp = 2'b10;
  logic [N-S-1:0] word;
  logic word_vld, sync_miss;
  logic [EW-1:0] erase_cnt;

  dpk_demod #(.W(W), .N(N), .S(S), .EW(EW)) u_dpk_demod (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp),
    .thr_rise(thr_rise), .thr_fall(thr_fall), .sync_exp(sync_exp),
    .word(word), .word_vld(word_vld), .sync_miss(sync_miss), .erase_cnt(erase_cnt));

  always #4 clk = ~clk;

  // {sync[1:0], data[7:0]}
  localparam logic [9:0] TBL [8] = '{
    10'b10_00111001, 10'b10_11111111, 10'b10_00000000, 10'b01_11110000,
    10'b10_10101010, 10'b11_01010101, 10'b10_01100110, 10'b10_11000011};

  int errs = 0, checks = 0;
  int pos_last, neg_last;
  bit pol, gap;
  logic [7:0] expw [64];
  int wr, rd, miss_exp, miss_seen;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int v);
    smp = W'(v); smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    if (gap) begin smp = 12'sh7ff; @(negedge clk); smp = -12'sd2048; @(negedge clk); end
  endtask

  task automatic send_bit(input bit b);
    if (!pol) begin pos_last += b ? 20 : -20; put(pos_last); end
    else      begin neg_last += b ? 20 : -20; put(neg_last); end
    pol = !pol;
  endtask

  task automatic send_erase();
    if (!pol) begin pos_last += 5; put(pos_last); end
    else      begin neg_last += 5; put(neg_last); end
    pol = !pol;
  endtask

  task automatic prime();
    put(0); put(1000); put(-1000);
    pos_last = 1000; neg_last = -1000; pol = 1'b0;
  endtask

  task automatic send_frame(input logic [9:0] f);
    for (int i = 9; i >= 8; i--) send_bit(f[i]);
    if (f[9:8] == sync_exp) begin
      expw[wr] = f[7:0]; wr++;
      for (int i = 7; i >= 0; i--) send_bit(f[i]);
    end else miss_exp++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; smp_vld = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    wr = 0; rd = 0; miss_exp = 0; miss_seen = 0;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (word_vld) begin
      chk(rd < wr && word == expw[rd], "R3 R6 word", int'(word), int'(expw[rd]));
      rd++;
    end
    if (sync_miss) miss_seen++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    gap = 1'b0;
    repeat (2) @(negedge clk);
    chk(word_vld == 1'b0, "R1 word_vld", int'(word_vld), 0);
    chk(sync_miss == 1'b0, "R1 sync_miss", int'(sync_miss), 0);
    chk(erase_cnt == '0, "R1 erase_cnt", int'(erase_cnt), 0);
    chk(word == '0, "R1 word", int'(word), 0);

    // table walk: back-to-back frames, matching and mismatching sync
    do_reset();
    prime();
    put(pos_last + 20); pos_last += 20; pol = 1'b1;
    chk(erase_cnt == '0, "R4 reference peaks", int'(erase_cnt), 0);
    pos_last -= 20; // above peak decoded bit 1: restart alignment cleanly via reset instead
    do_reset();
    prime();
    chk(erase_cnt == '0, "R4 no erasure from references", int'(erase_cnt), 0);
    for (int k = 0; k < 8; k++) send_frame(TBL[k]);
    put(0);
    repeat (2) @(negedge clk);
    chk(rd == wr, "R8 word count", rd, wr);
    chk(miss_seen == miss_exp, "R7 sync mismatch count", miss_seen, miss_exp);
    chk(erase_cnt == '0, "R5 no erasure on clear steps", int'(erase_cnt), 0);

    // exact valid timing
    do_reset();
    prime();
    send_frame(10'b10_10011011);
    put(0);
    chk(word_vld == 1'b1, "R6 valid cycle after deciding sample", int'(word_vld), 1);
    chk(word == 8'b10011011, "R6 word at pulse", int'(word), 8'b10011011);
    @(negedge clk);
    chk(word_vld == 1'b0, "R6 single-cycle pulse", int'(word_vld), 0);

    // erasure inside a frame
    do_reset();
    prime();
    send_bit(1'b1); send_bit(1'b0);
    expw[wr] = 8'b11010010; wr++;
    for (int i = 7; i >= 4; i--) send_bit(expw[0][i]);
    send_erase();
    for (int i = 3; i >= 0; i--) send_bit(expw[0][i]);
    put(0);
    repeat (2) @(negedge clk);
    chk(erase_cnt == 8'd1, "R5 erasure counted", int'(erase_cnt), 1);
    chk(rd == wr, "R5 alignment kept across erasure", rd, wr);

    // plateau hides a positive peak
    do_reset();
    prime();
    put(1200); put(1200); pol = 1'b1;
    send_frame(10'b10_01110001);
    put(0);
    repeat (2) @(negedge clk);
    chk(rd == wr, "R2 plateau gives no peak", rd, wr);

    // idle cycles with garbage samples
    do_reset();
    gap = 1'b1;
    prime();
    send_frame(10'b10_00101101);
    send_frame(10'b00_00000000);
    send_frame(10'b10_11100100);
    put(0);
    gap = 1'b0;
    repeat (2) @(negedge clk);
    chk(rd == wr, "R9 idle cycles ignored", rd, wr);
    chk(miss_seen == miss_exp, "R9 R7 idle mismatch count", miss_seen, miss_exp);

    // saturation
    do_reset();
    prime();
    for (int i = 0; i < 300; i++) send_erase();
    put(0);
    @(negedge clk);
    chk(erase_cnt == 8'hff, "R5 saturation", int'(erase_cnt), 255);
    chk(rd == 0, "R5 erasures give no word", rd, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule